// File: doc/BRIEF.md
# Audio Master Clock and Frame Clock Generator

This block turns one audio source clock into the three clocks an audio serial port needs when it runs as clock master: a divided master clock for an external converter, a bit clock, and a word-select (left/right) clock. A one-cycle slot-start strobe is also produced at the first bit of every slot, so the serializer does not have to detect word-select edges itself. All outputs are registers clocked by the source clock, so they carry no glitches.

Two 6-bit ratio fields set the rates. The master clock is the source clock divided by `div+1`. The frame (sample) period is `32*(fsr+1)` source cycles, and each frame holds two 32-bit slots. This gives a master clock of `32*(fsr+1)/(div+1)` times the sample rate, for example 256x with div=7 and fsr=63, or 1536x with div=0 and fsr=47. A start pulse launches the generator only while master operation is selected. The ratios and the master-clock output mode are captured at that pulse. A stop pulse lets the current frame finish, and the outputs then rest low until the next start.

Top module: `audio_clkgen`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge) the generator is idle and mck_o, bclk_o, ws_o and slot_start_o are all 0.
- R2: A start pulse sampled at a clock edge while master_i=1 and the generator is idle starts it. The outputs stay 0 up to that edge and one edge later show output time t=0, where slot_start_o=1.
- R3: A start pulse sampled while master_i=0 is ignored, and all outputs stay 0.
- R4: With the mode bit at 1 (mck_mode_i=1), mck_o at output time t is 1 when (t mod (div+1)) < floor((div+2)/2). The period is div+1 source cycles, and div=0 gives a steady 1.
- R5: With the mode bit at 0, mck_o stays 0 while the bit and frame clocks still run.
- R6: The bit period is P=(fsr+1)/2 source cycles, where fsr is odd and at least 3. bclk_o is 0 for the first floor(P/2) cycles of each bit and 1 for the rest.
- R7: ws_o is 0 for bits 0 to 31 of a frame and 1 for bits 32 to 63. A frame lasts 64*P = 32*(fsr+1) source cycles.
- R8: slot_start_o is 1 for exactly the first source cycle of bit 0 and of bit 32, which is every word-select edge, and bclk_o is 0 in that cycle.
- R9: A stop pulse while running lets the current frame run to its last cycle. From the next cycle on, all outputs are 0.
- R10: Changes on div_i, fsr_i and mck_mode_i while the generator runs have no effect. The values are taken only at a start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Audio source clock |
| rst_n | input | 1 | Synchronous active-low reset |
| master_i | input | 1 | 1 = this side drives the clocks; starts are honoured only then |
| mck_mode_i | input | 1 | 1 = drive the divided master clock on mck_o |
| div_i | input | 6 | Master clock divider field (divide by div+1) |
| fsr_i | input | 6 | Frame ratio field (frame = 32*(fsr+1) cycles) |
| ck_en_i | input | 1 | Start command pulse |
| ck_dis_i | input | 1 | Stop command pulse |
| mck_o | output | 1 | Master clock |
| bclk_o | output | 1 | Bit clock |
| ws_o | output | 1 | Word-select clock |
| slot_start_o | output | 1 | One-cycle strobe at the first bit of each slot |

## Verification
The bench compares every output cycle by cycle against a model built from the ratio formulas. It covers odd divide ratios, where a wrong rounding of the high phase would stretch or shrink mck_o, and the smallest bit period of two cycles, where an off-by-one in the bit counter would merge bclk_o edges. A stop pulse is issued in the middle of a frame: a design that stopped at once would cut the frame short, and one that ignored the stop would keep toggling past the frame end. The ratio inputs and the mode bit are changed while running, and a start is tried in slave mode. A design that failed to latch the settings at start, or to check master_i, would change rate or start toggling.

// File: rtl/clkgen_pkg.sv
// Shared widths and the captured configuration record of the clock generator.
package clkgen_pkg;
    localparam int DIV_W = 6;
    localparam int FSR_W = 6;

    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic [FSR_W-1:0] fsr;
        logic             mck_on;
    } clk_cfg_t;
endpackage

// File: rtl/clkgen_ctrl.sv
// Run/stop control of the clock generator.
// Starts on a start pulse only when master operation is selected, latching the
// configuration at that moment. A stop pulse is held pending until the frame
// generator reports the last cycle of a frame.
// Assumes single-cycle command pulses in the source clock domain.
module clkgen_ctrl
    import clkgen_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     start_i,
    input  logic     stop_i,
    input  logic     master_i,
    input  clk_cfg_t cfg_i,
    input  logic     frame_last_i,
    output logic     run_o,
    output clk_cfg_t cfg_o
);
    logic     run_q;
    logic     stop_pend_q;
    clk_cfg_t cfg_q;

    // Start/stop sequencing and configuration capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q       <= 1'b0;
            stop_pend_q <= 1'b0;
            cfg_q       <= '0;
        end else if (!run_q) begin
            stop_pend_q <= 1'b0;
            if (start_i && master_i) begin
                run_q <= 1'b1;
                cfg_q <= cfg_i;
            end
        end else begin
            if (stop_i) begin
                stop_pend_q <= 1'b1;
            end
            if ((stop_pend_q || stop_i) && frame_last_i) begin
                run_q <= 1'b0;
            end
        end
    end

    assign run_o = run_q;
    assign cfg_o = cfg_q;
endmodule

// File: rtl/clkgen_mck_div.sv
// Master clock divider: divides the source clock by div+1.
// The output is high for the first ceil((div+1)/2) cycles of each period.
// The output is registered, so it has no glitches. It is held low while
// stopped or when the master clock output is switched off.
module clkgen_mck_div
    import clkgen_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             mck_on_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             mck_o
);
    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W:0]   high_len;
    logic             mck_q;

    assign high_len = ({1'b0, div_i} + (DIV_W+1)'(2)) >> 1;

    // Phase counter, cleared while stopped.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i) begin
            cnt_q <= '0;
        end else if (cnt_q == div_i) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Registered output level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mck_q <= 1'b0;
        end else begin
            mck_q <= run_i && mck_on_i && ({1'b0, cnt_q} < high_len);
        end
    end

    assign mck_o = mck_q;
endmodule

// File: rtl/clkgen_frame.sv
// Bit clock, word-select clock and slot-start strobe generator.
// A bit lasts P=(fsr+1)/2 source cycles. A frame holds two slots of
// SLOT_BITS bits. Assumes fsr is odd and at least 3.
// Reports the last cycle of each frame so that a stop takes effect there.
module clkgen_frame
    import clkgen_pkg::*;
#(
    parameter int SLOT_BITS = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic [FSR_W-1:0] fsr_i,
    output logic             bclk_o,
    output logic             ws_o,
    output logic             slot_start_o,
    output logic             frame_last_o
);
    localparam int FRAME_BITS = 2 * SLOT_BITS;
    localparam int BIDX_W     = $clog2(FRAME_BITS);
    localparam int BP_W       = FSR_W - 1;

    logic [BP_W-1:0]   bp_q;
    logic [BIDX_W-1:0] bi_q;
    logic [BIDX_W-1:0] bi_next;
    logic [FSR_W:0]    p_len;
    logic [BP_W-1:0]   bp_last;
    logic [BP_W-1:0]   bp_half;
    logic              bit_last;
    logic              bclk_q, ws_q, ss_q;

    assign p_len    = {1'b0, fsr_i} + (FSR_W+1)'(1);
    assign bp_last  = fsr_i[FSR_W-1:1];
    assign bp_half  = p_len[FSR_W:2];
    assign bit_last = (bp_q == bp_last);
    assign frame_last_o = run_i && bit_last && (bi_q == BIDX_W'(FRAME_BITS - 1));

    // Bit index wrap: free wrap for a power-of-two frame, explicit compare otherwise.
    generate
        if ((1 << BIDX_W) == FRAME_BITS) begin : g_pow2_wrap
            assign bi_next = bi_q + 1'b1;
        end else begin : g_cmp_wrap
            assign bi_next = (bi_q == BIDX_W'(FRAME_BITS - 1)) ? '0 : bi_q + 1'b1;
        end
    endgenerate

    // Bit phase and bit index counters, cleared while stopped.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i) begin
            bp_q <= '0;
            bi_q <= '0;
        end else if (bit_last) begin
            bp_q <= '0;
            bi_q <= bi_next;
        end else begin
            bp_q <= bp_q + 1'b1;
        end
    end

    // Registered clock and strobe outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bclk_q <= 1'b0;
            ws_q   <= 1'b0;
            ss_q   <= 1'b0;
        end else begin
            bclk_q <= run_i && (bp_q >= bp_half);
            ws_q   <= run_i && (bi_q >= BIDX_W'(SLOT_BITS));
            ss_q   <= run_i && (bp_q == '0) &&
                      ((bi_q == '0) || (bi_q == BIDX_W'(SLOT_BITS)));
        end
    end

    assign bclk_o       = bclk_q;
    assign ws_o         = ws_q;
    assign slot_start_o = ss_q;
endmodule

// File: rtl/audio_clkgen.sv
// Top of the audio clock generator: master clock divider plus bit/frame clocks.
// Runs entirely in the audio source clock domain. Commands are single-cycle pulses.
module audio_clkgen
    import clkgen_pkg::*;
#(
    parameter int SLOT_BITS = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             master_i,
    input  logic             mck_mode_i,
    input  logic [DIV_W-1:0] div_i,
    input  logic [FSR_W-1:0] fsr_i,
    input  logic             ck_en_i,
    input  logic             ck_dis_i,
    output logic             mck_o,
    output logic             bclk_o,
    output logic             ws_o,
    output logic             slot_start_o
);
    clk_cfg_t cfg_in;
    clk_cfg_t cfg_q;
    logic     run;
    logic     frame_last;

    assign cfg_in = '{div: div_i, fsr: fsr_i, mck_on: mck_mode_i};

    clkgen_ctrl u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (ck_en_i),
        .stop_i       (ck_dis_i),
        .master_i     (master_i),
        .cfg_i        (cfg_in),
        .frame_last_i (frame_last),
        .run_o        (run),
        .cfg_o        (cfg_q)
    );

    clkgen_mck_div u_mck (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_i    (run),
        .mck_on_i (cfg_q.mck_on),
        .div_i    (cfg_q.div),
        .mck_o    (mck_o)
    );

    clkgen_frame #(.SLOT_BITS(SLOT_BITS)) u_frame (
        .clk          (clk),
        .rst_n        (rst_n),
        .run_i        (run),
        .fsr_i        (cfg_q.fsr),
        .bclk_o       (bclk_o),
        .ws_o         (ws_o),
        .slot_start_o (slot_start_o),
        .frame_last_o (frame_last)
    );
endmodule

// File: rtl/clkgen_checker.sv
// Temporal properties of the clock generator, bound to the top module.
module clkgen_checker
    import clkgen_pkg::*;
(
    input logic     clk,
    input logic     rst_n,
    input logic     run,
    input clk_cfg_t cfg,
    input logic     en,
    input logic     master,
    input logic     mck,
    input logic     bclk,
    input logic     ws,
    input logic     ss
);
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (!mck && !bclk && !ws && !ss));

    a_r3_slave_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !master && !run) |=> !run);

    a_r5_mck_off: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !cfg.mck_on) |=> !mck);

    a_r8_ws_rise_marks_slot: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ws) |-> ss);

    a_r8_slot_on_bclk_low: assert property (@(posedge clk) disable iff (!rst_n)
        ss |-> !bclk);

    a_r10_cfg_held: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run)) |-> $stable(cfg));
endmodule

bind audio_clkgen clkgen_checker u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (run),
    .cfg    (cfg_q),
    .en     (ck_en_i),
    .master (master_i),
    .mck    (mck_o),
    .bclk   (bclk_o),
    .ws     (ws_o),
    .ss     (slot_start_o)
);

// File: tb/test_audio_clkgen.sv
`timescale 1ns/1ps
module test_audio_clkgen;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       master_i = 1'b0;
    logic       mck_mode_i = 1'b0;
    logic [5:0] div_i = '0;
    logic [5:0] fsr_i = '0;
    logic       ck_en_i = 1'b0;
    logic       ck_dis_i = 1'b0;
    logic       mck_o, bclk_o, ws_o, slot_start_o;

    int n_checks = 0;
    int n_errors = 0;

    always #2.5 clk = ~clk;

    audio_clkgen i_audio_clkgen (
        .clk(clk), .rst_n(rst_n), .master_i(master_i), .mck_mode_i(mck_mode_i),
        .div_i(div_i), .fsr_i(fsr_i), .ck_en_i(ck_en_i), .ck_dis_i(ck_dis_i),
        .mck_o(mck_o), .bclk_o(bclk_o), .ws_o(ws_o), .slot_start_o(slot_start_o)
    );

    typedef struct packed {
        logic [5:0] div;
        logic [5:0] fsr;
        logic       mode;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{div: 6'd7, fsr: 6'd63, mode: 1'b1},
        '{div: 6'd7, fsr: 6'd31, mode: 1'b1},
        '{div: 6'd7, fsr: 6'd15, mode: 1'b1},
        '{div: 6'd0, fsr: 6'd47, mode: 1'b1},
        '{div: 6'd4, fsr: 6'd15, mode: 1'b0},
        '{div: 6'd2, fsr: 6'd3,  mode: 1'b1}
    };

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    endtask

    // Start, run two frames with a stop pulse inside the second, compare every cycle.
    task automatic run_case(input int div, input int fsr, input bit mode, input bit scramble);
        int p = (fsr + 1) / 2;
        int f = 64 * p;
        int e_mck = 0, e_bclk = 0, e_ws = 0, e_ss = 0, e_stop = 0;
        @(negedge clk);
        master_i = 1'b1; div_i = 6'(div); fsr_i = 6'(fsr); mck_mode_i = mode; ck_en_i = 1'b1;
        @(negedge clk);
        ck_en_i = 1'b0;
        // R2: outputs still low one edge after the start is sampled
        check({mck_o, bclk_o, ws_o, slot_start_o} == 4'b0, "R2 quiet before t0",
              int'({mck_o, bclk_o, ws_o, slot_start_o}), 0);
        if (scramble) begin
            div_i = ~6'(div); fsr_i = 6'd3; mck_mode_i = ~mode;
        end
        for (int t = 0; t < 2 * f + 4; t++) begin
            @(negedge clk);
            ck_dis_i = (t == f + 5);
            begin
                bit act = (t < 2 * f);
                bit em = act && mode && ((t % (div + 1)) < ((div + 2) / 2));
                bit eb = act && ((t % p) >= (p / 2));
                bit ew = act && (((t / p) % 64) >= 32);
                bit es = act && ((t % p) == 0) && (((t / p) % 32) == 0);
                if (t == 0) check(slot_start_o == 1'b1, "R2 slot strobe at t0", int'(slot_start_o), 1);
                if (!act) begin
                    if ({mck_o, bclk_o, ws_o, slot_start_o} != 4'b0) e_stop++;
                end else begin
                    if (mck_o != em) e_mck++;
                    if (bclk_o != eb) e_bclk++;
                    if (ws_o != ew) e_ws++;
                    if (slot_start_o != es) e_ss++;
                end
            end
        end
        ck_dis_i = 1'b0;
        if (scramble) begin
            check(e_mck + e_bclk + e_ws + e_ss == 0, "R10 settings held while running",
                  e_mck + e_bclk + e_ws + e_ss, 0);
        end else begin
            check(e_mck == 0, mode ? "R4 mck waveform" : "R5 mck held low", e_mck, 0);
            check(e_bclk == 0, "R6 bclk waveform", e_bclk, 0);
            check(e_ws == 0, "R7 ws waveform", e_ws, 0);
            check(e_ss == 0, "R8 slot strobe", e_ss, 0);
        end
        check(e_stop == 0, "R9 quiet after stop at frame end", e_stop, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        check(1'b0, "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        // R1: reset state
        check({mck_o, bclk_o, ws_o, slot_start_o} == 4'b0, "R1 reset outputs",
              int'({mck_o, bclk_o, ws_o, slot_start_o}), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check({mck_o, bclk_o, ws_o, slot_start_o} == 4'b0, "R1 idle after reset",
              int'({mck_o, bclk_o, ws_o, slot_start_o}), 0);

        // R3: start in slave mode is ignored
        begin
            int seen = 0;
            master_i = 1'b0; div_i = 6'd1; fsr_i = 6'd3; mck_mode_i = 1'b1; ck_en_i = 1'b1;
            @(negedge clk);
            ck_en_i = 1'b0;
            for (int i = 0; i < 40; i++) begin
                @(negedge clk);
                if ({mck_o, bclk_o, ws_o, slot_start_o} != 4'b0) seen++;
            end
            check(seen == 0, "R3 slave start ignored", seen, 0);
        end

        // Vector table: R2, R4-R9 over several ratio settings
        for (int v = 0; v < NV; v++) begin
            run_case(int'(VECS[v].div), int'(VECS[v].fsr), VECS[v].mode, 1'b0);
        end

        // R10: inputs changed while running
        run_case(7, 15, 1'b1, 1'b1);

        // R1: reset while running returns outputs to 0
        @(negedge clk);
        master_i = 1'b1; div_i = 6'd3; fsr_i = 6'd7; mck_mode_i = 1'b1; ck_en_i = 1'b1;
        @(negedge clk);
        ck_en_i = 1'b0;
        repeat (10) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check({mck_o, bclk_o, ws_o, slot_start_o} == 4'b0, "R1 reset while running",
              int'({mck_o, bclk_o, ws_o, slot_start_o}), 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check({mck_o, bclk_o, ws_o, slot_start_o} == 4'b0, "R1 idle after mid-run reset",
              int'({mck_o, bclk_o, ws_o, slot_start_o}), 0);
        finish_run();
    end
endmodule